// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Break

This block turns parallel words into asynchronous serial frames. A word written into a one-entry holding register goes to an output shift register as soon as the shifter is free. The shifter then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. All state, including the serial line, changes on the falling edge of a free-running transmit clock. Each bit lasts 1, 16 or 64 of those clocks.

A 3-bit word select code sets the data length, the parity mode and the stop-bit count. The format and the clock ratio are captured when a frame starts, so a change made in the middle of a frame applies to the next one. An empty flag tells the writer when the holding register can take a new word. A break request holds the line low. A master reset abandons any frame in progress and returns the block to idle.

Top module: `uart_tx_core`

## Requirements
- R1: A synchronous reset (`rst` or `mstr_rst` high at a falling edge) discards the held word and any frame in progress. After that edge `tx_out` is 1 and `tx_empty` is 1.
- R2: `tx_empty` goes to 0 after the falling edge where `wr_en` is sampled high. It returns to 1 after the edge where the held word moves into the shifter.
- R3: If the shifter is idle, a held word enters the shifter at the next falling edge, and the start bit appears on `tx_out` after that edge. If the shifter is busy, the word waits. It enters at the edge that ends the last stop bit, so its start bit follows that stop bit with no idle gap.
- R4: A frame is a 0 start bit, then the data bits from bit 0 upward, then the parity bit when enabled, then 1-valued stop bits.
- R5: `word_sel` selects the format:

  | Code | Data bits | Parity | Stop bits |
  |---|---|---|---|
  | 000 | 7 | even | 2 |
  | 001 | 7 | odd | 2 |
  | 010 | 7 | even | 1 |
  | 011 | 7 | odd | 1 |
  | 100 | 8 | none | 2 |
  | 101 | 8 | none | 1 |
  | 110 | 8 | even | 1 |
  | 111 | 8 | odd | 1 |

- R6: In the 7-bit formats, bit 7 of the written word is never sent. It has no effect on the parity bit.
- R7: With even parity, the data bits plus the parity bit hold an even number of ones. With odd parity, they hold an odd number.
- R8: `div_sel` 00 gives 1 clock per bit, 01 gives 16 clocks per bit, and 10 or 11 give 64 clocks per bit. `tx_out` changes only at falling edges of `clk`.
- R9: While `brk` is sampled high at falling edges, `tx_out` is 0 after each of those edges. Frame timing continues underneath, and the line shows the frame again once `brk` is low.
- R10: When no frame is being sent and `brk` is low, `tx_out` is 1.
- R11: `word_sel` and `div_sel` are captured when a word enters the shifter. Changing them during a frame does not change that frame.
- R12: A write while the holding register is full replaces the held word. Only the last word written before the shifter takes it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transmit clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to transmit |
| div_sel | input | 2 | Clocks-per-bit select |
| word_sel | input | 3 | Data length, parity and stop-bit select |
| brk | input | 1 | Break request, holds the line low |
| mstr_rst | input | 1 | Master reset; aborts the frame and returns to idle |
| tx_out | output | 1 | Serial line |
| tx_empty | output | 1 | Holding register empty |

## Verification
Every result is due one falling edge after its cause:
- `tx_empty` falls after the edge that samples a write.
- The start bit appears after the following edge when the shifter is idle.
- Each later bit boundary comes exactly 1, 16 or 64 edges after the previous one.
- Break and master reset act on the edge that samples them.

The bench drives inputs on rising edges and advances a queue-based reference model on every falling edge. It compares `tx_out` and `tx_empty` with the model at the following rising edge, half a period after the design has settled. The stimulus covers:
- all eight formats;
- each clock ratio;
- back-to-back and overwriting writes;
- a format change in mid-frame;
- a break in mid-frame;
- a master reset in mid-frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;
    localparam int CNT_W   = 4;

    typedef struct packed {
        logic       is8;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   len;
    } frame_t;

    function automatic fmt_t decode_fmt(input logic [2:0] ws);
        fmt_t f;
        f.is8      = ws[2];
        f.par_en   = (ws != 3'b100) && (ws != 3'b101);
        f.par_odd  = ws[0];
        f.two_stop = (ws == 3'b000) || (ws == 3'b001) || (ws == 3'b100);
        return f;
    endfunction

    function automatic frame_t build_frame(input fmt_t f, input logic [DATA_W-1:0] d);
        frame_t     fr;
        logic [3:0] nd;
        logic       par;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        nd         = f.is8 ? 4'd8 : 4'd7;
        par        = f.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nd)) begin
                fr.bits[i+1] = d[i];
                par          = par ^ d[i];
            end
        end
        if (f.par_en) fr.bits[nd + 4'd1] = par;
        fr.len = 4'd2 + nd + {3'b000, f.par_en} + {3'b000, f.two_stop};
        return fr;
    endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);
    always_ff @(negedge clk) begin
        if (clr) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic [2:0]        word_sel,
    input  logic [DATA_W-1:0] data,
    output frame_t            frame
);
    fmt_t fmt;
    always_comb begin
        fmt   = decode_fmt(word_sel);
        frame = build_frame(fmt, data);
    end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       hold_full,
    input  frame_t     frame,
    input  logic [1:0] div_sel,
    output logic       take,
    output logic       line
);
    localparam int DIV_W = $clog2(DIV_HI);

    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic [DIV_W-1:0]   tick;
    logic [DIV_W-1:0]   last;
    logic               bit_end;
    logic               frame_end;

    function automatic logic [DIV_W-1:0] ratio_m1(input logic [1:0] sel);
        case (sel)
            2'b00:   return '0;
            2'b01:   return DIV_W'(DIV_MID - 1);
            default: return DIV_W'(DIV_HI - 1);
        endcase
    endfunction

    assign bit_end   = busy && (tick == last);
    assign frame_end = bit_end && (left == CNT_W'(1));
    assign take      = hold_full && (!busy || frame_end);
    assign line      = busy ? shreg[0] : 1'b1;

    always_ff @(negedge clk) begin
        if (clr) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            tick  <= '0;
            last  <= '0;
        end else if (take) begin
            busy  <= 1'b1;
            shreg <= frame.bits;
            left  <= frame.len;
            tick  <= '0;
            last  <= ratio_m1(div_sel);
        end else if (frame_end) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            tick  <= '0;
        end else if (bit_end) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - CNT_W'(1);
            tick  <= '0;
        end else if (busy) begin
            tick  <= tick + DIV_W'(1);
        end
    end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DIV_MID = 16,
    parameter int DIV_HI  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        div_sel,
    input  logic [2:0]        word_sel,
    input  logic              brk,
    input  logic              mstr_rst,
    output logic              tx_out,
    output logic              tx_empty
);
    logic              clr;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              line;
    logic              brk_q;
    frame_t            frame;

    assign clr = rst | mstr_rst;

    uart_tx_hold i_hold (
        .clk       (clk),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    uart_tx_framer i_framer (
        .word_sel (word_sel),
        .data     (hold_data),
        .frame    (frame)
    );

    uart_tx_shift #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) i_shift (
        .clk       (clk),
        .clr       (clr),
        .hold_full (hold_full),
        .frame     (frame),
        .div_sel   (div_sel),
        .take      (take),
        .line      (line)
    );

    always_ff @(negedge clk) begin
        if (clr) brk_q <= 1'b0;
        else     brk_q <= brk;
    end

    assign tx_out   = line & ~brk_q;
    assign tx_empty = ~hold_full;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic brk,
    input logic mstr_rst,
    input logic tx_out,
    input logic tx_empty
);
    // R2
    wr_clears_empty_chk: assert property (@(negedge clk) disable iff (rst)
        (wr_en && !mstr_rst) |=> !tx_empty);

    // R9
    brk_low_chk: assert property (@(negedge clk) disable iff (rst)
        (brk && !mstr_rst) |=> !tx_out);

    // R1
    mreset_idle_chk: assert property (@(negedge clk) disable iff (rst)
        mstr_rst |=> (tx_out && tx_empty));

    // R3
    load_start_chk: assert property (@(negedge clk) disable iff (rst)
        ($rose(tx_empty) && !$past(mstr_rst) && !$past(rst)) |-> !tx_out);
endmodule

bind uart_tx_core uart_tx_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .brk      (brk),
    .mstr_rst (mstr_rst),
    .tx_out   (tx_out),
    .tx_empty (tx_empty)
);

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] div_sel = 2'b00;
    logic [2:0] word_sel = 3'b000;
    logic       brk = 1'b0;
    logic       mstr_rst = 1'b0;
    logic       tx_out;
    logic       tx_empty;

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    uart_tx_core i_uart_tx_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .div_sel(div_sel), .word_sel(word_sel), .brk(brk),
        .mstr_rst(mstr_rst), .tx_out(tx_out), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: a queue of line levels, one entry per bit period
    int   q[$];
    int   rem = 0;
    int   frame_ratio = 1;
    bit   m_full = 0;
    logic [7:0] m_data = 8'h00;
    bit   m_brk = 0;
    logic exp_tx = 1'b1;
    logic exp_empty = 1'b1;

    task automatic push_frame(input logic [7:0] d);
        int  nbits;
        int  stops;
        bit  pen;
        bit  par;
        nbits = word_sel[2] ? 8 : 7;                                 // R5
        stops = (word_sel == 3'd0 || word_sel == 3'd1 || word_sel == 3'd4) ? 2 : 1;
        pen   = !(word_sel == 3'd4 || word_sel == 3'd5);
        par   = word_sel[0];                                         // R7
        frame_ratio = (div_sel == 2'b00) ? 1 : (div_sel == 2'b01) ? 16 : 64;  // R8
        q.push_back(0);                                              // R4
        for (int i = 0; i < nbits; i++) begin                        // R6
            q.push_back(int'(d[i]));
            par ^= d[i];
        end
        if (pen) q.push_back(int'(par));
        for (int s = 0; s < stops; s++) q.push_back(1);
    endtask

    always @(negedge clk) begin
        if (rst || mstr_rst) begin
            q.delete();
            m_full = 0;
            m_brk  = 0;
            rem    = 0;
        end else begin
            if (q.size() > 0) begin
                rem--;
                if (rem == 0) begin
                    void'(q.pop_front());
                    rem = frame_ratio;
                end
            end
            if (q.size() == 0 && m_full) begin
                push_frame(m_data);
                rem    = frame_ratio;
                m_full = 0;
            end
            if (wr_en) begin
                m_data = wr_data;
                m_full = 1;
            end
            m_brk = brk;
        end
        exp_tx    = m_brk ? 1'b0 : ((q.size() > 0) ? q[0][0] : 1'b1);
        exp_empty = !m_full;
    end

    task automatic check1(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        check1(phase, tx_out, exp_tx, "tx_out");
        check1(phase, tx_empty, exp_empty, "tx_empty");
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic put(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0 || m_full) @(posedge clk);
        step(3);
    endtask

    bit done = 0;

    initial begin
        step(3);
        rst = 1'b0;
        check1("R1", tx_out, 1'b1, "tx_out after reset");
        check1("R1", tx_empty, 1'b1, "tx_empty after reset");
        step(4);

        phase = "R5";
        for (int ws = 0; ws < 8; ws++) begin
            word_sel = 3'(ws);
            put(8'hA5 ^ 8'(ws * 37));
            wait_idle();
        end

        phase = "R6";
        word_sel = 3'b011;
        put(8'h80);
        wait_idle();
        put(8'h7F);
        wait_idle();

        phase = "R7";
        word_sel = 3'b110;
        put(8'h01);
        wait_idle();
        word_sel = 3'b111;
        put(8'h03);
        wait_idle();

        phase = "R8";
        for (int dv = 1; dv < 4; dv++) begin
            div_sel  = 2'(dv);
            word_sel = 3'b101;
            put(8'h5A);
            wait_idle();
        end

        phase = "R3";
        div_sel  = 2'b00;
        word_sel = 3'b010;
        put(8'h11);
        put(8'h22);
        wait_idle();

        phase = "R12";
        put(8'h33);
        put(8'h44);
        put(8'h55);
        wait_idle();

        phase = "R11";
        div_sel = 2'b01;
        put(8'h96);
        step(40);
        div_sel  = 2'b00;
        word_sel = 3'b111;
        put(8'h69);
        wait_idle();

        phase = "R9";
        div_sel  = 2'b01;
        word_sel = 3'b100;
        put(8'hC3);
        step(30);
        brk = 1'b1;
        step(50);
        brk = 1'b0;
        wait_idle();

        phase = "R10";
        step(20);

        phase = "R1";
        div_sel = 2'b01;
        put(8'h0F);
        put(8'hF0);
        step(25);
        mstr_rst = 1'b1;
        step(1);
        mstr_rst = 1'b0;
        step(1);
        check1("R1", tx_out, 1'b1, "tx_out after master reset");
        check1("R1", tx_empty, 1'b1, "tx_empty after master reset");
        step(40);

        phase = "R2";
        div_sel = 2'b00;
        put(8'hE7);
        wait_idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule